// File: doc/BRIEF.md
# Return-Channel CRC Error Tally

This block keeps a record of CRC error events seen on a return channel. It holds two saturating counters of the same width. The functional counter collects every error reported while the link is locked. The self-test counter collects errors only while the self-test flag is asserted.

Entering self-test restarts both records from zero. When the test ends, the self-test counter keeps its final value so software can read the outcome of the last run. That value stays until software clears it or another test begins. A software clear strobe empties both counters at any time.

The CRC computation, the link and the register bus decode sit outside this block. The block only sees a lock status, a one-cycle error pulse, the test-mode level and the clear strobe, and it drives the two counter values.

Top module: `crc_err_tally`

## Requirements
- R1: A synchronous reset (rst high at a rising clk edge) sets func_count and test_count to zero.
- R2: With link_up high, each cycle in which crc_err is high adds one to func_count, whether or not test_mode is high.
- R3: While link_up is low, crc_err changes neither counter.
- R4: Neither counter wraps: at 255 (all ones at the default width of 8) further error pulses leave it at 255.
- R5: test_count adds one for a crc_err pulse only when test_mode and link_up are both high in that cycle.
- R6: A cycle where test_mode is high and was low in the previous cycle sets both counters to zero after that edge, and a crc_err pulse in that same cycle is not counted.
- R7: After test_mode falls, test_count holds its value until sw_clr or the next rising edge of test_mode.
- R8: sw_clr high sets both counters to zero after that edge, and it wins over a crc_err pulse in the same cycle.
- R9: Holding test_mode high for many cycles clears the counters only once, on the first cycle of the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Lock indication for the return stream |
| crc_err | input | 1 | One pulse per detected CRC error |
| test_mode | input | 1 | Self-test active level |
| sw_clr | input | 1 | Software clear strobe, one cycle |
| func_count | output | CNT_W | Functional-mode error count |
| test_count | output | CNT_W | Self-test error count |

## Verification
The assertions assume that every input is synchronous to clk and already free of glitches, and that one crc_err cycle stands for exactly one error event. They also assume that test_mode is a level whose rising edge is taken to mean a new test. The bench drives all inputs on the falling edge, so each one is stable across a full rising edge. It mixes random levels and pulses with directed sequences for saturation, same-cycle clear-and-error cases, and a test flag held high for a long time.

// File: rtl/crc_err_tally.sv
module crc_err_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             crc_err,
  input  logic             test_mode,
  input  logic             sw_clr,
  output logic [CNT_W-1:0] func_count,
  output logic [CNT_W-1:0] test_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic test_q;
  logic entry;
  logic wipe;
  logic hit;

  assign entry = test_mode & ~test_q;
  assign wipe  = sw_clr | entry;
  assign hit   = link_up & crc_err;

  always_ff @(posedge clk) begin
    if (rst) test_q <= 1'b0;
    else     test_q <= test_mode;
  end

  always_ff @(posedge clk) begin
    if (rst || wipe)                      func_count <= '0;
    else if (hit && func_count != CNT_MAX) func_count <= func_count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || wipe)                                   test_count <= '0;
    else if (hit && test_mode && test_count != CNT_MAX) test_count <= test_count + 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (func_count == '0 && test_count == '0)); // R1
  AST_NO_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!link_up && !sw_clr && !entry) |=> ($stable(func_count) && $stable(test_count))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (func_count == CNT_MAX && !sw_clr && !entry) |=> func_count == CNT_MAX); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!sw_clr && !entry) |=> (func_count == $past(func_count) || func_count == $past(func_count) + 1'b1)); // R2
  AST_TEST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !sw_clr) |=> $stable(test_count)); // R7
  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !test_q) |=> (func_count == '0 && test_count == '0)); // R6
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sw_clr |=> (func_count == '0 && test_count == '0)); // R8
endmodule

// File: tb/sim_crc_err_tally.sv
module sim_crc_err_tally;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b0, crc_err = 1'b0, test_mode = 1'b0, sw_clr = 1'b0;
  logic [7:0] func_count, test_count;

  int checks = 0;
  int errors = 0;
  int ef = 0, et = 0;
  bit tprev = 1'b0;

  always #2.5 clk = ~clk;

  crc_err_tally #(.CNT_W(8)) u0 (
    .clk(clk), .rst(rst), .link_up(link_up), .crc_err(crc_err),
    .test_mode(test_mode), .sw_clr(sw_clr),
    .func_count(func_count), .test_count(test_count)
  );

  function automatic int next_cnt(int cur, bit wipe, bit inc);
    if (wipe) return 0;
    if (inc && cur < 255) return cur + 1;
    return cur;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit l, bit e, bit t, bit c, string tag);
    bit wipe;
    @(negedge clk);
    link_up = l; crc_err = e; test_mode = t; sw_clr = c;
    @(posedge clk);
    wipe = c | (t & ~tprev);
    ef = next_cnt(ef, wipe, l & e);
    et = next_cnt(et, wipe, l & e & t);
    tprev = t;
    #1;
    check({tag, " func"}, func_count, ef);
    check({tag, " test"}, test_count, et);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 func", func_count, 0);
    check("R1 test", test_count, 0);

    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R3");
    step(1, 1, 0, 1, "R8 clear beats error");
    for (int i = 0; i < 260; i++) step(1, 1, 0, 0, "R4");
    check("R4 saturated", func_count, 255);
    step(1, 1, 1, 0, "R6 entry drops pulse");
    check("R6 func zero", func_count, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 1, 0, "R5 R9");
    step(0, 1, 1, 0, "R3 in test");
    step(1, 0, 0, 0, "R7 exit");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, "R7 hold");
    check("R7 kept", test_count, 7);
    for (int i = 0; i < 300; i++) step(1, 1, 1, 0, "R4 R9 test");
    check("R4 test sat", test_count, 255);
    step(1, 1, 1, 1, "R8 in test");

    for (int i = 0; i < 4000; i++) begin
      bit t;
      t = ($urandom % 64 == 0) ? ~test_mode : test_mode;
      step($urandom % 8 != 0, $urandom % 3 == 0, t, $urandom % 97 == 0, "R2 R5 random");
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 func again", func_count, 0);
    check("R1 test again", test_count, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule